// File: doc/BRIEF.md
# Run-Mode Clock Controller

This block chooses the clock source of a small microcontroller and derives the CPU and USB clock enables from it. Software writes an 8-bit mode register to request full power, which routes the 60 MHz PLL output to the dividers. The request only takes effect once the PLL reports lock. Until then the block keeps running from the 12 MHz oscillator. The CPU enable is the chosen source divided by 2 or by 4. The USB enable is active only while the PLL is the source.

All clocks are clock-enable pulses on one fast reference clock `clk`, which stands for 60 MHz. The oscillator is one pulse every `OSC_DIV` reference cycles (default 5, giving 12 MHz). The PLL source is a pulse on every cycle. The register also holds a regulator-off flag. Software sets it before entering halt, and the block clears it when `wake_halt` pulses.

The state machine has three states:
- `ST_LOW`: oscillator source, PLL off.
- `ST_WAIT`: full power requested, still on the oscillator, waiting for lock.
- `ST_FULL`: PLL source, USB enabled.

It has these transitions:
- LOW→WAIT when the run-mode bit is set.
- WAIT→FULL when the synchronized lock is high.
- WAIT→LOW and FULL→LOW when the run-mode bit is cleared.
- FULL→WAIT when the synchronized lock falls.

Top module: `runclk_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 00h, `pll_en`, `src_is_pll` and `usb_ce` are 0, and the CPU enable comes every 2*OSC_DIV cycles.
- R2: The register layout is:
  - bit 7: regulator-off flag
  - bit 2: synchronized lock status
  - bit 1: run mode (1 = full power)
  - bit 0: divide select (0 = /2, 1 = /4)

  Bits 7, 1 and 0 are writable. Writes to bit 2 and to bits 6:3 are ignored, and bits 6:3 always read 0.
- R3: `pll_lock_async` passes through two flops. Bit 2 of `reg_rdata` shows a rising lock on the second clock edge after the input rises, and not on the first.
- R4: `pll_en` equals the run-mode bit. It is therefore high in both WAIT and FULL.
- R5: With run mode 1 and no lock, the source stays the oscillator. The CPU enable period is 2*OSC_DIV or 4*OSC_DIV cycles, there are no USB pulses, and the PLL source is never chosen without first passing through WAIT.
- R6: With run mode 1 and lock, the source is the PLL, `usb_ce` is high on every cycle, and the CPU period is 2 or 4 cycles.
- R7: Clearing the run-mode bit while in FULL drops `pll_en`, `src_is_pll` and `usb_ce` in the first cycle after the write edge.
- R8: If the synchronized lock falls while in FULL, the block returns to the oscillator with no USB pulses, and `pll_en` stays high.
- R9: A change of divide select takes effect only when the CPU enable fires. The period in progress keeps its old length, and no two CPU pulses are ever adjacent.
- R10: A `wake_halt` pulse clears bit 7 and leaves the other register bits unchanged. If it coincides with a write, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast reference clock (models 60 MHz) |
| rst_n | input | 1 | active-low asynchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_wdata | input | 8 | register write data |
| reg_rdata | output | 8 | register read data |
| pll_lock_async | input | 1 | PLL lock, asynchronous |
| wake_halt | input | 1 | one-cycle wake-from-halt pulse |
| pll_en | output | 1 | PLL enable request |
| src_is_pll | output | 1 | PLL is the active source |
| cpu_ce | output | 1 | CPU clock enable pulse |
| usb_ce | output | 1 | USB clock enable pulse |

## Verification
The hardest situations to reach are a divide-select change that lands in the middle of a CPU period, and a lock loss while in FULL. For the first, the bench aligns to a CPU pulse, counts a fixed number of reference cycles and writes the new select. It then expects the current interval to keep its old length and the next one to take the new length. For the second, the bench sweeps every combination of run mode, lock and divide select, then drops the lock input while in FULL. It expects the periods computed from OSC_DIV and the divider ratio.

// File: rtl/runclk_pkg.sv
package runclk_pkg;
    typedef enum logic [1:0] {
        ST_LOW  = 2'd0,
        ST_WAIT = 2'd1,
        ST_FULL = 2'd2
    } run_state_t;

    localparam int REG_W   = 8;
    localparam int B_REGOFF = 7;
    localparam int B_LOCK   = 2;
    localparam int B_MODE   = 1;
    localparam int B_FRQ    = 0;
endpackage

// File: rtl/runclk_sync.sv
module runclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/runclk_div.sv
module runclk_div #(
    parameter int OSC_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_pll,
    input  logic div_sel,
    output logic cpu_ce
);
    localparam int OSC_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
    localparam logic [OSC_W-1:0] OSC_LAST = OSC_W'(OSC_DIV - 1);

    logic [OSC_W-1:0] osc_cnt;
    logic             osc_tick;
    logic             src_ce;
    logic [1:0]       phase;
    logic             act_div4;
    logic [1:0]       phase_last;
    logic             at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 osc_cnt <= '0;
        else if (osc_cnt == OSC_LAST) osc_cnt <= '0;
        else                        osc_cnt <= osc_cnt + 1'b1;
    end

    assign osc_tick   = (osc_cnt == OSC_LAST);
    assign src_ce     = use_pll | osc_tick;
    assign phase_last = act_div4 ? 2'd3 : 2'd1;
    assign at_end     = src_ce && (phase == phase_last);
    assign cpu_ce     = at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            act_div4 <= 1'b0;
        end else if (at_end) begin
            phase    <= '0;
            act_div4 <= div_sel;
        end else if (src_ce) begin
            phase    <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/runclk_ctrl.sv
module runclk_ctrl
    import runclk_pkg::*;
#(
    parameter int OSC_DIV     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       pll_lock_async,
    input  logic       wake_halt,
    output logic       pll_en,
    output logic       src_is_pll,
    output logic       cpu_ce,
    output logic       usb_ce
);
    run_state_t state_q, state_d;
    logic regoff_q, mode_q, frq_q;
    logic lock_s;

    runclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pll_lock_async),
        .q       (lock_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regoff_q <= 1'b0;
            mode_q   <= 1'b0;
            frq_q    <= 1'b0;
        end else begin
            if (wake_halt)   regoff_q <= 1'b0;
            else if (reg_we) regoff_q <= reg_wdata[B_REGOFF];
            if (reg_we) begin
                mode_q <= reg_wdata[B_MODE];
                frq_q  <= reg_wdata[B_FRQ];
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (mode_q) state_d = ST_WAIT;
            ST_WAIT: if (!mode_q) state_d = ST_LOW;
                     else if (lock_s) state_d = ST_FULL;
            ST_FULL: if (!mode_q) state_d = ST_LOW;
                     else if (!lock_s) state_d = ST_WAIT;
            default: state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        pll_en     = mode_q;
        src_is_pll = (state_q == ST_FULL) && mode_q && lock_s;
        usb_ce     = src_is_pll;
        reg_rdata  = '0;
        reg_rdata[B_REGOFF] = regoff_q;
        reg_rdata[B_LOCK]   = lock_s;
        reg_rdata[B_MODE]   = mode_q;
        reg_rdata[B_FRQ]    = frq_q;
    end

    runclk_div #(.OSC_DIV(OSC_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .use_pll (src_is_pll),
        .div_sel (frq_q),
        .cpu_ce  (cpu_ce)
    );
endmodule

// File: rtl/runclk_ctrl_chk.sv
module runclk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       wake_halt,
    input logic       pll_en,
    input logic       src_is_pll,
    input logic       cpu_ce,
    input logic       usb_ce
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:3] == 4'b0000);

    p_pll_en_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_en == reg_rdata[1]);

    p_full_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src_is_pll) |-> $past(pll_en));

    p_lock_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_is_pll |-> $past(reg_rdata[2]));

    p_usb_only_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        usb_ce |-> pll_en);

    p_no_adjacent_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |=> !cpu_ce);

    p_wake_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_halt |=> !reg_rdata[7]);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(reg_rdata[1:0]));
endmodule

bind runclk_ctrl runclk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .wake_halt  (wake_halt),
    .pll_en     (pll_en),
    .src_is_pll (src_is_pll),
    .cpu_ce     (cpu_ce),
    .usb_ce     (usb_ce)
);

// File: tb/runclk_ctrl_tb.sv
module runclk_ctrl_tb_top;
    localparam int OSC_DIV = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pll_lock_async = 1'b0;
    logic       wake_halt = 1'b0;
    logic       pll_en, src_is_pll, cpu_ce, usb_ce;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    runclk_ctrl #(.OSC_DIV(OSC_DIV)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .pll_lock_async (pll_lock_async),
        .wake_halt      (wake_halt),
        .pll_en         (pll_en),
        .src_is_pll     (src_is_pll),
        .cpu_ce         (cpu_ce),
        .usb_ce         (usb_ce)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: act=%0d exp<=150000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_cpu();
        int n = 0;
        while (!cpu_ce && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic next_gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ce && n < 400);
    endtask

    task automatic meas(input int exp, input string req);
        int n;
        wait_cpu();
        for (int k = 0; k < 3; k++) begin
            next_gap(n);
            chk(n == exp, req, n, exp);
        end
    endtask

    task automatic usb_win(input bit exp_on, input string req);
        int cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (usb_ce) cnt++;
        end
        chk(cnt == (exp_on ? 40 : 0), req, cnt, exp_on ? 40 : 0);
    endtask

    initial begin
        int n;
        tick(3);
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
        chk({pll_en, src_is_pll, usb_ce} == 3'b000, "R1 outputs", {pll_en, src_is_pll, usb_ce}, 0);
        rst_n = 1'b1;
        tick(2);
        meas(2 * OSC_DIV, "R1 period");

        // R2 reserved and lock bits ignored on write
        wr(8'h7C);
        chk(reg_rdata == 8'h00, "R2 reserved/lock write", reg_rdata, 0);
        wr(8'h83);
        chk(reg_rdata == 8'h83, "R2 writable bits", reg_rdata, 8'h83);
        // R10 wake clears only bit 7
        wake_halt = 1'b1; tick(1); wake_halt = 1'b0;
        chk(reg_rdata == 8'h03, "R10 wake clear", reg_rdata, 3);
        wr(8'h80);
        wake_halt = 1'b1; reg_we = 1'b1; reg_wdata = 8'h80;
        tick(1);
        wake_halt = 1'b0; reg_we = 1'b0;
        chk(reg_rdata == 8'h00, "R10 wake wins over write", reg_rdata, 0);
        wake_halt = 1'b1; tick(1); wake_halt = 1'b0;
        chk(reg_rdata == 8'h00, "R10 wake with flag clear", reg_rdata, 0);

        // R3 lock synchronizer latency
        pll_lock_async = 1'b1;
        tick(1);
        chk(reg_rdata[2] == 1'b0, "R3 first edge", reg_rdata[2], 0);
        tick(1);
        chk(reg_rdata[2] == 1'b1, "R3 second edge", reg_rdata[2], 1);
        pll_lock_async = 1'b0;
        tick(3);

        // R4 R5 R6 sweep over mode, lock and divide select
        for (int m = 0; m < 2; m++) begin
            for (int l = 0; l < 2; l++) begin
                for (int f = 0; f < 2; f++) begin
                    int src, per;
                    pll_lock_async = l[0];
                    wr({6'b0, m[0], f[0]});
                    tick(30);
                    src = (m == 1 && l == 1) ? 1 : OSC_DIV;
                    per = src * ((f == 1) ? 4 : 2);
                    chk(reg_rdata == {5'b0, l[0], m[0], f[0]}, "R2 sweep rdata", reg_rdata, {5'b0, l[0], m[0], f[0]});
                    chk(pll_en == m[0], "R4 pll_en", pll_en, m);
                    chk(src_is_pll == (m == 1 && l == 1), "R5 R6 source", src_is_pll, (m == 1 && l == 1));
                    meas(per, (m == 1 && l == 1) ? "R6 period" : "R5 period");
                    usb_win(m == 1 && l == 1, (m == 1 && l == 1) ? "R6 usb" : "R5 usb");
                end
            end
        end

        // R7 leaving full power: drop in first cycle after write edge
        pll_lock_async = 1'b1;
        wr(8'h02);
        tick(10);
        chk(src_is_pll == 1'b1, "R7 precondition", src_is_pll, 1);
        wr(8'h00);
        chk({pll_en, src_is_pll, usb_ce} == 3'b000, "R7 immediate drop", {pll_en, src_is_pll, usb_ce}, 0);
        meas(2 * OSC_DIV, "R7 period after exit");

        // R8 lock loss while in FULL
        wr(8'h03);
        tick(10);
        chk(src_is_pll == 1'b1, "R8 precondition", src_is_pll, 1);
        pll_lock_async = 1'b0;
        tick(3);
        chk({pll_en, src_is_pll, usb_ce} == 3'b100, "R8 back to oscillator", {pll_en, src_is_pll, usb_ce}, 4);
        meas(4 * OSC_DIV, "R8 period");
        usb_win(1'b0, "R8 usb");
        wr(8'h00);

        // R9 divide change mid-period: /2 -> /4
        tick(20);
        wait_cpu();
        tick(3);
        wr(8'h01);
        n = 4;
        while (!cpu_ce && n < 400) begin @(negedge clk); n++; end
        chk(n == 2 * OSC_DIV, "R9 old period kept", n, 2 * OSC_DIV);
        next_gap(n);
        chk(n == 4 * OSC_DIV, "R9 new period", n, 4 * OSC_DIV);
        // /4 -> /2
        tick(2);
        wr(8'h00);
        n = 3;
        while (!cpu_ce && n < 400) begin @(negedge clk); n++; end
        chk(n == 4 * OSC_DIV, "R9 old period kept back", n, 4 * OSC_DIV);
        next_gap(n);
        chk(n == 2 * OSC_DIV, "R9 new period back", n, 2 * OSC_DIV);

        report();
    end
endmodule